// File: doc/BRIEF.md
# ARX Branch Mixer, Four Rounds

This unit mixes one 64-bit branch, held as two 32-bit words x and y, under a 32-bit branch constant c. It runs four add-rotate-xor rounds. In each round y, rotated right, is added to x. Then x, rotated right, is folded into y. Then c is XORed into x. Each round uses its own fixed pair of rotation amounts. A permutation core around the unit supplies the words and constants and does the mixing between branches.

Operands arrive on a valid/ready handshake and the result leaves on a second valid/ready handshake. The parameter `RPC` sets how many rounds are computed per clock (1, 2 or 4). With the default of 1, the area is one round datapath and the latency is four cycles. With 4, all rounds are done in one cycle. The first step is computed in the cycle the operands are accepted, so the latency is 4/RPC cycles.

Top module: `arx4_box`

## Requirements
- R1: Each round performs three steps in this order: x = (x + ror(y, r)) mod 2^32, then y = y ^ ror(x, s) using the updated x, then x = x ^ c.
- R2: Rounds 0 to 3 use the (r, s) right-rotation pairs (31, 24), (17, 17), (0, 31) and (24, 16), in that order.
- R3: The same input constant c is XORed into x at the end of each of the four rounds.
- R4: All words are 32 bits wide and additions wrap modulo 2^32, including all-ones operands.
- R5: Operands accepted at a clock edge (in_valid_i and in_ready_o both high) give out_valid_o high exactly 4/RPC edges later, and not before. This is 4 edges for RPC=1 and 1 edge for RPC=4.
- R6: in_ready_o is low while rounds are still pending, and low while out_valid_o is high and out_ready_i is low.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_x_o and out_y_o hold their values.
- R8: When out_valid_o and out_ready_i are both high, in_ready_o is high, so a new operand set can be accepted in the same cycle the result is taken.
- R9: While rst_ni is low, out_valid_o is low and in_ready_o is high.
- R10: in_valid_i has no effect while in_ready_o is low. The pending or held result is unchanged, and no extra result appears after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set offered |
| in_ready_o | output | 1 | Unit can accept operands |
| in_x_i | input | 32 | Word x |
| in_y_i | input | 32 | Word y |
| in_c_i | input | 32 | Branch constant |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| out_x_o | output | 32 | Mixed word x |
| out_y_o | output | 32 | Mixed word y |

## Verification
Result hand-off and operand acceptance can fall in the same cycle. The bench provokes this by holding a second operand set on the input while the first result comes out, with the consumer ready. It then judges that in_ready_o is high in that cycle, that the first result is correct, and that the second result follows exactly the round latency later with its own correct value. A further case stalls the consumer while new operands are offered. Here in_ready_o must stay low and the stalled result must hold.

// File: rtl/arx4_pkg.sv
package arx4_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_ROUNDS = 4;
  localparam int unsigned IDX_W    = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  ridx_t;

  function automatic word_t ror(word_t v, int unsigned n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction

  // per-round rotation applied to y before the add
  function automatic int unsigned rot_add(ridx_t i);
    case (i)
      2'd0:    return 31;
      2'd1:    return 17;
      2'd2:    return 0;
      default: return 24;
    endcase
  endfunction

  // per-round rotation applied to x before the fold into y
  function automatic int unsigned rot_fold(ridx_t i);
    case (i)
      2'd0:    return 24;
      2'd1:    return 17;
      2'd2:    return 31;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/arx4_round.sv
module arx4_round
  import arx4_pkg::*;
(
  input  ridx_t idx_i,
  input  word_t x_i,
  input  word_t y_i,
  input  word_t c_i,
  output word_t x_o,
  output word_t y_o
);
  int unsigned r_amt;
  int unsigned s_amt;
  word_t       x_sum;

  always_comb begin
    r_amt = rot_add(idx_i);
    s_amt = rot_fold(idx_i);
    x_sum = x_i + ror(y_i, r_amt);
  end

  assign y_o = y_i ^ ror(x_sum, s_amt);
  assign x_o = x_sum ^ c_i;
endmodule

// File: rtl/arx4_box.sv
module arx4_box
  import arx4_pkg::*;
#(
  parameter int unsigned RPC = 1  // rounds per clock: 1, 2 or 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_x_i,
  input  logic [WORD_W-1:0] in_y_i,
  input  logic [WORD_W-1:0] in_c_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_x_o,
  output logic [WORD_W-1:0] out_y_o
);
  localparam int unsigned STEPS = N_ROUNDS / RPC;
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  word_t            x_q, y_q, c_q;
  logic             busy_q, valid_q;
  logic [CNT_W-1:0] step_q;
  logic             accept;

  word_t            c_src;
  logic [CNT_W-1:0] step_src;
  word_t            chain_x [RPC+1];
  word_t            chain_y [RPC+1];

  assign in_ready_o = !busy_q && (!valid_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  // first step runs straight off the inputs in the accept cycle
  always_comb begin
    chain_x[0] = accept ? in_x_i : x_q;
    chain_y[0] = accept ? in_y_i : y_q;
    c_src      = accept ? in_c_i : c_q;
    step_src   = accept ? '0 : step_q;
  end

  for (genvar k = 0; k < RPC; k++) begin : g_round
    ridx_t idx_k;
    assign idx_k = IDX_W'(int'(step_src) * RPC + k);
    arx4_round u_round (
      .idx_i (idx_k),
      .x_i   (chain_x[k]),
      .y_i   (chain_y[k]),
      .c_i   (c_src),
      .x_o   (chain_x[k+1]),
      .y_o   (chain_y[k+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_q     <= '0;
      c_q     <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      step_q  <= '0;
    end else if (accept) begin
      x_q <= chain_x[RPC];
      y_q <= chain_y[RPC];
      c_q <= in_c_i;
      if (STEPS == 1) begin
        valid_q <= 1'b1;
        busy_q  <= 1'b0;
        step_q  <= '0;
      end else begin
        valid_q <= 1'b0;
        busy_q  <= 1'b1;
        step_q  <= CNT_W'(1);
      end
    end else if (busy_q) begin
      x_q <= chain_x[RPC];
      y_q <= chain_y[RPC];
      if (step_q == LAST_STEP) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        step_q  <= '0;
      end else begin
        step_q <= step_q + CNT_W'(1);
      end
    end else if (valid_q && out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_x_o     = x_q;
  assign out_y_o     = y_q;
endmodule

// File: rtl/arx4_box_chk.sv
module arx4_box_chk #(
  parameter int unsigned RPC = 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_x_o,
  input logic [31:0] out_y_o
);
  localparam int unsigned LAT = 4 / RPC;

  logic       acc;
  logic       pend_q;
  logic [2:0] cnt_q;

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (acc) begin
      pend_q <= 1'b1;
      cnt_q  <= 3'd1;
    end else if (pend_q && cnt_q == 3'(LAT)) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q <= cnt_q + 3'd1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R9: assert (!out_valid_o && in_ready_o);
    end
  end

  assert_no_early_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q != 3'(LAT)) |-> !out_valid_o);

  assert_result_on_time_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q == 3'(LAT)) |-> out_valid_o);

  assert_busy_blocks_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q != 3'(LAT)) |-> !in_ready_o);

  assert_stall_blocks_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_hold_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_x_o) && $stable(out_y_o)));

  assert_handoff_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !pend_q) |-> in_ready_o);

  assert_no_phantom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !out_valid_o && !acc) |=> !out_valid_o);
endmodule

bind arx4_box arx4_box_chk #(.RPC(RPC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_x_o     (out_x_o),
  .out_y_o     (out_y_o)
);

// File: tb/arx4_box_test.sv
`timescale 1ns/1ps
module arx4_box_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [31:0] in_x = '0, in_y = '0, in_c = '0, out_x, out_y;
  logic        f_in_valid = 1'b0;
  logic        f_in_ready, f_out_valid;
  logic [31:0] f_in_x = '0, f_in_y = '0, f_in_c = '0, f_out_x, f_out_y;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  arx4_box uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_x_i(in_x), .in_y_i(in_y), .in_c_i(in_c), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_x_o(out_x), .out_y_o(out_y));

  arx4_box #(.RPC(4)) uut_fast (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(f_in_valid), .in_ready_o(f_in_ready),
    .in_x_i(f_in_x), .in_y_i(f_in_y), .in_c_i(f_in_c), .out_valid_o(f_out_valid),
    .out_ready_i(1'b1), .out_x_o(f_out_x), .out_y_o(f_out_y));

  function automatic logic [31:0] rr(logic [31:0] v, int n);
    if (n == 0) return v;
    return (v >> n) | (v << (32 - n));
  endfunction

  // behavioural model: four rounds with pairs (31,24),(17,17),(0,31),(24,16)
  function automatic logic [63:0] model(logic [31:0] x, logic [31:0] y, logic [31:0] c);
    int ra [4] = '{31, 17, 0, 24};
    int sa [4] = '{24, 17, 31, 16};
    for (int i = 0; i < 4; i++) begin
      x = x + rr(y, ra[i]);
      y = y ^ rr(x, sa[i]);
      x = x ^ c;
    end
    return {x, y};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] x, input logic [31:0] y, input logic [31:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_y = y; in_c = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // returns cycles counted from the accept edge until out_valid seen
  task automatic collect(output int lat);
    lat = 1;
    while (!out_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_vec(input logic [31:0] x, input logic [31:0] y, input logic [31:0] c, input string req);
    int lat;
    logic [63:0] exp;
    exp = model(x, y, c);
    out_ready = 1'b1;
    send(x, y, c);
    collect(lat);
    check(lat == 4, "R5 latency", 64'(lat), 64'd4);
    check({out_x, out_y} == exp, req, {out_x, out_y}, exp);
    @(negedge clk);
    check(!out_valid, "R9 result consumed", 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    check(!out_valid, "R9 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready, "R9 in_ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R9 idle after reset", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  task automatic t_vectors;
    run_vec(32'h0, 32'h0, 32'h0, "R4 all-zero");
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 all-ones wrap");
    run_vec(32'h0000_0001, 32'h0, 32'h0, "R1 R2 single bit x");
    run_vec(32'h0, 32'h8000_0000, 32'h0, "R2 single bit y");
    run_vec(32'h1234_5678, 32'h9ABC_DEF0, 32'h0, "R1 c zero");
    run_vec(32'h1234_5678, 32'h9ABC_DEF0, 32'hB7E1_5162, "R3 c applied each round");
    run_vec(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hC2B3_293D, "R1 mixed");
  endtask

  task automatic t_stall;
    logic [63:0] exp;
    int lat;
    exp = model(32'hCAFE_0001, 32'h5555_AAAA, 32'h3C3C_3C3C);
    out_ready = 1'b0;
    send(32'hCAFE_0001, 32'h5555_AAAA, 32'h3C3C_3C3C);
    // offer other operands while busy
    in_valid = 1'b1; in_x = 32'h1111_1111; in_y = 32'h2222_2222; in_c = 32'h3333_3333;
    check(!in_ready, "R6 ready low while busy", 64'(in_ready), 64'd0);
    collect(lat);
    check(lat == 4, "R5 latency under stall", 64'(lat), 64'd4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && !in_ready, "R6 R7 stalled state", {62'd0, out_valid, in_ready}, 64'd2);
      check({out_x, out_y} == exp, "R7 R10 held result", {out_x, out_y}, exp);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check(!out_valid, "R10 no phantom result", 64'(out_valid), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_back_to_back;
    logic [63:0] ea, eb;
    int lat;
    ea = model(32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h4F7C_7B57);
    eb = model(32'h7777_0000, 32'h0000_7777, 32'hCFBF_A1C8);
    out_ready = 1'b1;
    send(32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h4F7C_7B57);
    in_x = 32'h7777_0000; in_y = 32'h0000_7777; in_c = 32'hCFBF_A1C8;
    collect(lat);
    in_valid = 1'b1;
    check(out_valid && in_ready, "R8 ready during hand-off", {62'd0, out_valid, in_ready}, 64'd3);
    check({out_x, out_y} == ea, "R8 first result", {out_x, out_y}, ea);
    @(negedge clk);
    in_valid = 1'b0;
    collect(lat);
    check(lat == 4, "R8 R5 second latency", 64'(lat), 64'd4);
    check({out_x, out_y} == eb, "R8 second result", {out_x, out_y}, eb);
    @(negedge clk);
  endtask

  task automatic t_fast;
    logic [63:0] exp;
    exp = model(32'h0123_4567, 32'h89AB_CDEF, 32'hBF71_5880);
    @(negedge clk);
    f_in_valid = 1'b1; f_in_x = 32'h0123_4567; f_in_y = 32'h89AB_CDEF; f_in_c = 32'hBF71_5880;
    check(f_in_ready, "R5 fast ready", 64'(f_in_ready), 64'd1);
    @(negedge clk);
    f_in_valid = 1'b0;
    check(f_out_valid, "R5 fast one-cycle latency", 64'(f_out_valid), 64'd1);
    check({f_out_x, f_out_y} == exp, "R1 fast result", {f_out_x, f_out_y}, exp);
    @(negedge clk);
    check(!f_out_valid, "R5 fast consumed", 64'(f_out_valid), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_vectors();
    t_stall();
    t_back_to_back();
    t_fast();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule